// File: doc/BRIEF.md
# Half-Bridge Gate Drive Controller

This block sequences the two switches of a synchronous half-bridge power stage. A PWM command comes in as two comparator flags: one reports that the PWM level is above the upper threshold, and the other reports that it is below the lower threshold. When neither flag is set, the level is in a mid-level tri-state band. The controller turns these flags into registered gate enables for the high-side and low-side switches. Before it turns on either gate, it waits until the opposite gate's sense input shows that gate has discharged. It then adds a fixed dead-time delay.

If the mid-level band lasts for a programmable hold-off period, the controller shuts both switches off. A shorter excursion into the band is ignored. An active-low disable input forces both gates off and parks the controller in its idle state. An active-low skip input masks the low-side switch so the stage runs non-synchronously with diode emulation. The PWM flags and the skip input are asynchronous and each passes through a two-flop synchronizer. The disable and gate-sense inputs are taken as synchronous to the clock.

Top module: `hb_gate_ctrl`

## Requirements
- R1: With `pwm_hi_i` high and `ls_gate_low_i` high from the idle state, `hs_en_o` rises on the (HOLD_DT+3)-th rising edge after the input change. The delay is two synchronizer edges, one edge to start waiting, and HOLD_DT waiting cycles.
- R2: With `pwm_lo_i` high (and `pwm_hi_i` low), the high-side gate turns off and `ls_en_o` rises HOLD_DT+3 edges after the change, provided `hs_gate_low_i` is high.
- R3: When both PWM flags stay low for longer than the hold-off, both gate enables go low on the (TRI_HOLD+3)-th edge after the flags drop.
- R4: A tri-state excursion shorter than TRI_HOLD synchronized cycles leaves the gate enables unchanged.
- R5: Once the PWM flags leave the tri-state band, switching resumes through the normal dead-time sequence.
- R6: While `dis_ni` is low, both gate enables are low from the next rising edge onward. When `dis_ni` is released, the controller restarts from the idle state.
- R7: When `skip_ni` is low, `ls_en_o` goes low by the third edge and stays low whatever the PWM level. The high side keeps working normally.
- R8: A gate enable rises only after the opposite sense input has been high for HOLD_DT consecutive waiting cycles. If that sense input drops while waiting, the count restarts.
- R9: If the opposite sense input never goes high, the requested gate stays off indefinitely.
- R10: `hs_en_o` and `ls_en_o` are never high in the same cycle.
- R11: When both PWM flags are high, the command is decoded as high-side on.
- R12: During reset both gate enables are low. The synchronizers reset to PWM flags low and skip inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_hi_i | input | 1 | Comparator flag: PWM above upper threshold (asynchronous) |
| pwm_lo_i | input | 1 | Comparator flag: PWM below lower threshold (asynchronous) |
| dis_ni | input | 1 | Disable, active low, synchronous |
| skip_ni | input | 1 | Skip mode, active low: masks low side (asynchronous) |
| hs_gate_low_i | input | 1 | High-side gate discharged below the low threshold |
| ls_gate_low_i | input | 1 | Low-side gate discharged below the low threshold |
| hs_en_o | output | 1 | High-side gate enable, registered |
| ls_en_o | output | 1 | Low-side gate enable, registered |

## Verification
The assertions assume that `dis_ni` and the two sense inputs change only between clock edges, as a synchronous source would drive them. They also assume that the skip and PWM flags reach the logic only through the synchronizers, so the latency of the PWM and skip paths is exactly three edges. The stimulus drives every input at the falling edge. It holds tri-state and skip windows long enough to cross the synchronizers. In its random phase, it lets the sense inputs drop freely in the middle of a wait so that the restart behaviour of the dead-time count is exercised.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic [1:0] {
    CMD_OFF = 2'd0,
    CMD_HS  = 2'd1,
    CMD_LS  = 2'd2
  } hbg_cmd_e;

  typedef enum logic [2:0] {
    ST_OFF, ST_HS_WAIT, ST_HS_ON, ST_LS_WAIT, ST_LS_ON
  } hbg_state_e;
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int unsigned   W       = 1,
  parameter int unsigned   STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hbg_pwm_dec.sv
module hbg_pwm_dec
  import hbg_pkg::*;
#(
  parameter int unsigned TRI_HOLD = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hi_i,
  input  logic     lo_i,
  output hbg_cmd_e cmd_o
);
  localparam int unsigned CW = $clog2(TRI_HOLD + 1);

  logic [CW-1:0] tri_cnt_q;
  hbg_cmd_e      last_q;
  logic          in_tri, expired;

  assign in_tri  = !hi_i && !lo_i;
  assign expired = (tri_cnt_q == CW'(TRI_HOLD));

  // hi wins over lo; a short tri-state excursion keeps the last command
  always_comb begin
    if (hi_i)         cmd_o = CMD_HS;
    else if (lo_i)    cmd_o = CMD_LS;
    else if (expired) cmd_o = CMD_OFF;
    else              cmd_o = last_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tri_cnt_q <= '0;
      last_q    <= CMD_OFF;
    end else begin
      if (!in_tri)      tri_cnt_q <= '0;
      else if (!expired) tri_cnt_q <= CW'(tri_cnt_q + 1'b1);
      if (!in_tri) last_q <= cmd_o;
    end
  end
endmodule

// File: rtl/hbg_dt_fsm.sv
module hbg_dt_fsm
  import hbg_pkg::*;
#(
  parameter int unsigned HOLD_DT = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     dis_ni,
  input  hbg_cmd_e cmd_i,
  input  logic     skip_ni,
  input  logic     hs_low_i,
  input  logic     ls_low_i,
  output logic     hs_en_o,
  output logic     ls_en_o
);
  localparam int unsigned DW = $clog2(HOLD_DT + 1);

  hbg_state_e    st_q, st_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic          want_hs, want_ls;

  assign want_hs = (cmd_i == CMD_HS);
  assign want_ls = (cmd_i == CMD_LS) && skip_ni;

  always_comb begin
    st_d   = st_q;
    dcnt_d = '0;
    unique case (st_q)
      ST_OFF: begin
        if (want_hs)      st_d = ST_HS_WAIT;
        else if (want_ls) st_d = ST_LS_WAIT;
      end
      ST_HS_WAIT: begin
        if (!want_hs) st_d = want_ls ? ST_LS_WAIT : ST_OFF;
        else if (ls_low_i) begin
          if (dcnt_q == DW'(HOLD_DT - 1)) st_d = ST_HS_ON;
          else dcnt_d = DW'(dcnt_q + 1'b1);
        end
      end
      ST_HS_ON: if (!want_hs) st_d = want_ls ? ST_LS_WAIT : ST_OFF;
      ST_LS_WAIT: begin
        if (!want_ls) st_d = want_hs ? ST_HS_WAIT : ST_OFF;
        else if (hs_low_i) begin
          if (dcnt_q == DW'(HOLD_DT - 1)) st_d = ST_LS_ON;
          else dcnt_d = DW'(dcnt_q + 1'b1);
        end
      end
      ST_LS_ON: if (!want_ls) st_d = want_hs ? ST_HS_WAIT : ST_OFF;
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_OFF;
      dcnt_q  <= '0;
      hs_en_o <= 1'b0;
      ls_en_o <= 1'b0;
    end else if (!dis_ni) begin
      st_q    <= ST_OFF;
      dcnt_q  <= '0;
      hs_en_o <= 1'b0;
      ls_en_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      dcnt_q  <= dcnt_d;
      hs_en_o <= (st_d == ST_HS_ON);
      ls_en_o <= (st_d == ST_LS_ON);
    end
  end
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int unsigned TRI_HOLD = 16,
  parameter int unsigned HOLD_DT  = 4,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_hi_i,
  input  logic pwm_lo_i,
  input  logic dis_ni,
  input  logic skip_ni,
  input  logic hs_gate_low_i,
  input  logic ls_gate_low_i,
  output logic hs_en_o,
  output logic ls_en_o
);
  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] async_in, sync_out;
  hbg_cmd_e         cmd;

  assign async_in = {skip_ni, pwm_hi_i, pwm_lo_i};

  hbg_sync #(
    .W(NSYNC), .STAGES(SYNC_LEN), .RST_VAL(3'b100)
  ) sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(async_in), .q_o(sync_out)
  );

  hbg_pwm_dec #(.TRI_HOLD(TRI_HOLD)) dec_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hi_i(sync_out[1]), .lo_i(sync_out[0]), .cmd_o(cmd)
  );

  hbg_dt_fsm #(.HOLD_DT(HOLD_DT)) fsm_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .dis_ni(dis_ni), .cmd_i(cmd),
    .skip_ni(sync_out[2]), .hs_low_i(hs_gate_low_i), .ls_low_i(ls_gate_low_i),
    .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
  );
endmodule

// File: rtl/hbg_chk.sv
module hbg_chk #(
  parameter int unsigned TRI_HOLD = 16,
  parameter int unsigned HOLD_DT  = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pwm_hi_i,
  input logic pwm_lo_i,
  input logic dis_ni,
  input logic skip_ni,
  input logic hs_gate_low_i,
  input logic ls_gate_low_i,
  input logic hs_en_o,
  input logic ls_en_o
);
  localparam int unsigned GW = $clog2(HOLD_DT + 1);
  localparam int unsigned TW = $clog2(TRI_HOLD + 4);

  logic [1:0]    warm_q;
  logic [GW-1:0] gap_q;
  logic [TW-1:0] tri_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_q <= '0;
      gap_q  <= '0;
      tri_q  <= '0;
    end else begin
      if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
      if (hs_en_o || ls_en_o)          gap_q <= '0;
      else if (gap_q != GW'(HOLD_DT))  gap_q <= GW'(gap_q + 1'b1);
      if (pwm_hi_i || pwm_lo_i)            tri_q <= '0;
      else if (tri_q != TW'(TRI_HOLD + 3)) tri_q <= TW'(tri_q + 1'b1);
    end
  end

  assert_no_overlap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o));

  assert_disable_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dis_ni |=> (!hs_en_o && !ls_en_o));

  assert_hs_sensed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> ($past(ls_gate_low_i) && gap_q >= GW'(HOLD_DT)));

  assert_ls_sensed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_en_o) |-> ($past(hs_gate_low_i) && gap_q >= GW'(HOLD_DT)));

  assert_skip_masks_ls_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && !$past(skip_ni, 3)) |-> !ls_en_o);

  assert_tri_hold_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tri_q >= TW'(TRI_HOLD + 3)) |-> (!hs_en_o && !ls_en_o));
endmodule

bind hb_gate_ctrl hbg_chk #(.TRI_HOLD(TRI_HOLD), .HOLD_DT(HOLD_DT)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwm_hi_i(pwm_hi_i), .pwm_lo_i(pwm_lo_i),
  .dis_ni(dis_ni), .skip_ni(skip_ni), .hs_gate_low_i(hs_gate_low_i),
  .ls_gate_low_i(ls_gate_low_i), .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
);

// File: tb/hb_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module hb_gate_ctrl_tb_top;
  localparam int TRI_HOLD = 16;
  localparam int HOLD_DT  = 4;

  logic clk_i = 1'b0;
  logic rst_ni, pwm_hi_i, pwm_lo_i, dis_ni, skip_ni, hs_gate_low_i, ls_gate_low_i;
  logic hs_en_o, ls_en_o;

  int    checks = 0, fails = 0;
  string cur_req = "R12";
  bit    done = 1'b0;

  always #2 clk_i = ~clk_i;

  hb_gate_ctrl #(.TRI_HOLD(TRI_HOLD), .HOLD_DT(HOLD_DT)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwm_hi_i(pwm_hi_i), .pwm_lo_i(pwm_lo_i),
    .dis_ni(dis_ni), .skip_ni(skip_ni), .hs_gate_low_i(hs_gate_low_i),
    .ls_gate_low_i(ls_gate_low_i), .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // Behavioural reference: delay lines for the synchronizers, integer timers
  bit hq[$], lq[$], kq[$];
  int tri_len, prev_cmd, mode, wait_len;  // mode: 0 idle,1 wait hs,2 hs,3 wait ls,4 ls
  bit e_hs, e_ls;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hq = '{0, 0}; lq = '{0, 0}; kq = '{1, 1};
      tri_len = 0; prev_cmd = 0; mode = 0; wait_len = 0;
      e_hs = 0; e_ls = 0;
    end else begin
      bit h, l, k, wh, wl;
      int cmd;
      h = hq.pop_front(); l = lq.pop_front(); k = kq.pop_front();
      hq.push_back(pwm_hi_i); lq.push_back(pwm_lo_i); kq.push_back(skip_ni);
      cmd = h ? 1 : l ? 2 : (tri_len >= TRI_HOLD) ? 0 : prev_cmd;
      if (h || l) begin tri_len = 0; prev_cmd = cmd; end
      else if (tri_len < TRI_HOLD) tri_len++;
      wh = (cmd == 1);
      wl = (cmd == 2) && k;
      if (!dis_ni) begin
        mode = 0; wait_len = 0;
      end else begin
        int nm, nw;
        nm = mode; nw = 0;
        if (mode == 0) nm = wh ? 1 : wl ? 3 : 0;
        else if (mode == 2) begin if (!wh) nm = wl ? 3 : 0; end
        else if (mode == 4) begin if (!wl) nm = wh ? 1 : 0; end
        else if (mode == 1) begin
          if (!wh) nm = wl ? 3 : 0;
          else if (ls_gate_low_i) begin
            if (wait_len + 1 >= HOLD_DT) nm = 2; else nw = wait_len + 1;
          end
        end else begin
          if (!wl) nm = wh ? 1 : 0;
          else if (hs_gate_low_i) begin
            if (wait_len + 1 >= HOLD_DT) nm = 4; else nw = wait_len + 1;
          end
        end
        mode = nm; wait_len = nw;
      end
      e_hs = (mode == 2);
      e_ls = (mode == 4);
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(hs_en_o == e_hs, cur_req, "hs_en_o vs model", hs_en_o, e_hs);
      chk(ls_en_o == e_ls, cur_req, "ls_en_o vs model", ls_en_o, e_ls);
      chk(!(hs_en_o && ls_en_o), "R10", "overlap", 1, 0);
    end
  end

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_ni = 0; pwm_hi_i = 0; pwm_lo_i = 0; dis_ni = 1; skip_ni = 1;
    hs_gate_low_i = 1; ls_gate_low_i = 1;
    cyc(3);
    chk(!hs_en_o && !ls_en_o, "R12", "gates in reset", {hs_en_o, ls_en_o}, 0);
    rst_ni = 1;
    cyc(2);

    cur_req = "R1"; pwm_hi_i = 1;
    cyc(HOLD_DT + 2);
    chk(hs_en_o == 0, "R8", "hs before dead time", hs_en_o, 0);
    cyc(1);
    chk(hs_en_o == 1, "R1", "hs on", hs_en_o, 1);

    cur_req = "R2"; pwm_hi_i = 0; pwm_lo_i = 1;
    cyc(HOLD_DT + 3);
    chk(ls_en_o == 1 && hs_en_o == 0, "R2", "ls on hs off", {hs_en_o, ls_en_o}, 1);

    cur_req = "R9"; ls_gate_low_i = 0; pwm_lo_i = 0; pwm_hi_i = 1;
    cyc(50);
    chk(!hs_en_o && !ls_en_o, "R9", "blocked by sense", {hs_en_o, ls_en_o}, 0);
    cur_req = "R8"; ls_gate_low_i = 1;
    cyc(HOLD_DT - 1);
    chk(hs_en_o == 0, "R8", "hs one cycle early", hs_en_o, 0);
    cyc(1);
    chk(hs_en_o == 1, "R8", "hs after sense+delay", hs_en_o, 1);

    cur_req = "R4"; pwm_hi_i = 0;
    cyc(TRI_HOLD / 2);
    pwm_hi_i = 1;
    cyc(5);
    chk(hs_en_o == 1, "R4", "short tri ignored", hs_en_o, 1);

    cur_req = "R3"; pwm_hi_i = 0;
    cyc(TRI_HOLD + 2);
    chk(hs_en_o == 1, "R3", "hs before hold-off", hs_en_o, 1);
    cyc(1);
    chk(!hs_en_o && !ls_en_o, "R3", "both off after hold-off", {hs_en_o, ls_en_o}, 0);
    cyc(10);

    cur_req = "R5"; pwm_lo_i = 1;
    cyc(HOLD_DT + 3);
    chk(ls_en_o == 1, "R5", "ls resumes", ls_en_o, 1);

    cur_req = "R7"; skip_ni = 0;
    cyc(2);
    chk(ls_en_o == 1, "R7", "ls before skip seen", ls_en_o, 1);
    cyc(1);
    chk(ls_en_o == 0, "R7", "ls masked", ls_en_o, 0);
    cyc(20);
    chk(ls_en_o == 0, "R7", "ls stays masked", ls_en_o, 0);
    pwm_lo_i = 0; pwm_hi_i = 1;
    cyc(HOLD_DT + 3);
    chk(hs_en_o == 1, "R7", "hs works in skip", hs_en_o, 1);
    pwm_hi_i = 0; pwm_lo_i = 1;
    cyc(HOLD_DT + 5);
    chk(!hs_en_o && !ls_en_o, "R7", "lo ignored in skip", {hs_en_o, ls_en_o}, 0);
    skip_ni = 1;
    cyc(HOLD_DT + 3);
    chk(ls_en_o == 1, "R7", "ls after skip off", ls_en_o, 1);

    cur_req = "R6"; dis_ni = 0;
    cyc(1);
    chk(!hs_en_o && !ls_en_o, "R6", "disable off", {hs_en_o, ls_en_o}, 0);
    pwm_lo_i = 0; pwm_hi_i = 1;
    cyc(10);
    chk(!hs_en_o && !ls_en_o, "R6", "held off", {hs_en_o, ls_en_o}, 0);
    dis_ni = 1;
    cyc(HOLD_DT + 1);
    chk(hs_en_o == 1, "R6", "restart after enable", hs_en_o, 1);

    cur_req = "R11"; pwm_hi_i = 0; pwm_lo_i = 1;
    cyc(HOLD_DT + 3);
    pwm_hi_i = 1;
    cyc(HOLD_DT + 3);
    chk(hs_en_o == 1 && ls_en_o == 0, "R11", "both flags -> hs", {hs_en_o, ls_en_o}, 2);

    cur_req = "R10";
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk_i);
      if ($urandom % 10 == 0) begin
        int r = $urandom % 4;
        pwm_hi_i = (r == 0) || (r == 3);
        pwm_lo_i = (r == 1) || (r == 3);
      end
      if ($urandom % 60 == 0) skip_ni = ~skip_ni;
      if ($urandom % 80 == 0) dis_ni = ~dis_ni;
      hs_gate_low_i = ($urandom % 5) != 0;
      ls_gate_low_i = ($urandom % 5) != 0;
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule